// File: doc/BRIEF.md
# Register Access SPI Master

This block drives a full-duplex SPI link to an external peripheral that exposes a small register file. The host logic asks for one register transaction at a time. Each request names a 5-bit register, says whether it reads or writes, and carries a write byte. The block then runs one frame of exactly two bytes. The first byte is a command built from the register number and the direction. The second byte is either the write data or a zero filler.

While the command byte goes out, the peripheral answers with a status byte. The block keeps that byte for both reads and writes. On a read, the byte that comes back during the second slot is the register value. On a write, the byte that comes back during the second slot is thrown away.

The serial clock is made from the system clock through a divider set by a parameter. The serial clock rests low. Data changes while the serial clock is low and is sampled at the end of each high half. A one-cycle completion pulse marks the end of each frame. A short enforced pause keeps frames apart.

Top module: `spi_regacc`

## Requirements
- R1: While and after reset, `spi_ss_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, and `busy` and `done` are 0.
- R2: The first byte sent holds the register number in bits 7:3 and the direction in bit 1 (1 = write, 0 = read). Bits 2 and 0 are 0. Every byte is sent most significant bit first.
- R3: On a read, the second byte sent is 0x00. The byte received in that slot appears on `rd_data` once the frame ends.
- R4: On a write, the second byte sent is `req_wdata`. `rd_data` keeps its earlier value.
- R5: The byte received during the command byte appears on `status` after both read and write frames.
- R6: `spi_ss_n` stays low for the whole frame. A frame has exactly 16 rising edges of `spi_sclk`. `spi_sclk` is low whenever `spi_ss_n` is high.
- R7: Each half-period of `spi_sclk` lasts `HALF_DIV` system clocks, so `spi_ss_n` is low for 32*`HALF_DIV` cycles. `spi_mosi` changes only while `spi_sclk` is low. `spi_miso` is sampled in the last cycle of each high half.
- R8: A request is taken only while `busy` is 0. A request raised while `busy` is 1 starts no frame and does not change the frame in progress.
- R9: `done` is high for exactly one cycle, in the first cycle in which `spi_ss_n` is high again. `busy` then stays high for `HALF_DIV` cycles in total, counting the `done` cycle. As a result, `spi_ss_n` is high for at least `HALF_DIV` cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a transaction (taken only when idle) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_reg | input | 5 | Register number |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A frame or the pause after it is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 8 | Register value from the last read |
| status | output | 8 | Status byte from the last frame |
| spi_ss_n | output | 1 | Slave select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the peripheral |
| spi_miso | input | 1 | Serial data from the peripheral |

## Verification
The bench builds the block with `HALF_DIV` = 3. This value makes each half-period longer than one cycle, so an off-by-one in the divider changes the measured frame length (96 cycles) and the measured pause (3 cycles). A divider value of 1 could not show these errors.

A peripheral model in the bench answers with a known status byte and holds a register file. This lets the bench check, at the pins, which command and data bytes arrived, and which bytes were returned, using corner registers 0 and 31 and data values 0x00 and 0xFF.

// File: rtl/spi_regacc_pkg.sv
// Package spi_regacc_pkg
// Shared constants, the sequencer state type and the command byte builder.
// Assumes an 8-bit byte and a 5-bit register number as the frame layout needs.
package spi_regacc_pkg;
    localparam int BYTE_W     = 8;
    localparam int REG_W      = 5;
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int DIR_BIT    = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_t;

    // Register number in the top bits, direction flag in bit DIR_BIT, rest zero.
    function automatic logic [BYTE_W-1:0] make_cmd(input logic [REG_W-1:0] rnum,
                                                   input logic wr);
        logic [BYTE_W-1:0] c;
        c = '0;
        c[BYTE_W-1 -: REG_W] = rnum;
        c[DIR_BIT] = wr;
        return c;
    endfunction
endpackage

// File: rtl/spi_regacc_tick.sv
// Module spi_regacc_tick
// Half-period timer: while run is high, tick pulses every HALF_DIV cycles.
// Assumes run drops only together with a tick or while idle; the count restarts on each tick.
module spi_regacc_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks inside the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // R7: the count never passes the end of a half-period
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/spi_regacc_shift.sv
// Module spi_regacc_shift
// Frame shifter: a transmit register sends its MSB first and fills with zeros;
// a receive byte collects the sampled input at the LSB.
// Assumes load and step are never high in the same cycle.
module spi_regacc_shift #(
    parameter int TX_W = 16,
    parameter int RX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            step,
    input  logic            sin,
    output logic            sout,
    output logic [RX_W-1:0] rx_byte
);
    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    assign sout    = tx_q[TX_W-1];
    assign rx_byte = rx_q;

    // Transmit register: load a whole frame, shift one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n)    tx_q <= '0;
        else if (load) tx_q <= load_word;
        else if (step) tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end

    // Receive register: clear at frame start, take one sample per step.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_q <= '0;
        else if (load) rx_q <= '0;
        else if (step) rx_q <= {rx_q[RX_W-2:0], sin};
    end

    // R2: a freshly loaded frame presents its top bit first
    a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sout == $past(load_word[TX_W-1])));
endmodule

// File: rtl/spi_regacc.sv
// Module spi_regacc
// Full-duplex SPI master for one-register transactions: command byte plus one data byte.
// Returns the status byte seen during the command and, on reads, the register value.
// Assumes the peripheral changes MISO while SCLK is low. HALF_DIV >= 1.
module spi_regacc #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_wr,
    input  logic [4:0] req_reg,
    input  logic [7:0] req_wdata,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic [7:0] status,
    output logic       spi_ss_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    import spi_regacc_pkg::*;

    localparam int BC_W = $clog2(FRAME_BITS);
    localparam logic [BC_W-1:0] CMD_LAST   = BC_W'(BYTE_W - 1);
    localparam logic [BC_W-1:0] FRAME_LAST = BC_W'(FRAME_BITS - 1);

    seq_state_t        state;
    logic [BC_W-1:0]   bitcnt;
    logic              is_wr;
    logic              tick;
    logic              load;
    logic              step;
    logic [BYTE_W-1:0] rx_byte;
    logic [FRAME_BITS-1:0] frame_word;
    logic [BYTE_W-1:0] sampled;

    assign busy       = (state != ST_IDLE);
    assign load       = (state == ST_IDLE) && req;
    assign step       = (state == ST_HIGH) && tick;
    assign frame_word = {make_cmd(req_reg, req_wr), (req_wr ? req_wdata : {BYTE_W{1'b0}})};
    assign sampled    = {rx_byte[BYTE_W-2:0], spi_miso};

    spi_regacc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    spi_regacc_shift #(.TX_W(FRAME_BITS), .RX_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (frame_word),
        .step      (step),
        .sin       (spi_miso),
        .sout      (spi_mosi),
        .rx_byte   (rx_byte)
    );

    // Frame sequencer: select, clock phases, bit count, result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            spi_ss_n <= 1'b1;
            spi_sclk <= 1'b0;
            done     <= 1'b0;
            bitcnt   <= '0;
            is_wr    <= 1'b0;
            status   <= '0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        state    <= ST_LOW;
                        spi_ss_n <= 1'b0;
                        bitcnt   <= '0;
                        is_wr    <= req_wr;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        spi_sclk <= 1'b1;
                        state    <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        spi_sclk <= 1'b0;
                        bitcnt   <= bitcnt + 1'b1;
                        if (bitcnt == CMD_LAST) status <= sampled;
                        if (bitcnt == FRAME_LAST) begin
                            spi_ss_n <= 1'b1;
                            done     <= 1'b1;
                            state    <= ST_GAP;
                            if (!is_wr) rd_data <= sampled;
                        end else begin
                            state <= ST_LOW;
                        end
                    end
                end
                default: begin
                    if (tick) state <= ST_IDLE;
                end
            endcase
        end
    end

    // R6: the serial clock rests low whenever the peripheral is deselected
    a_r6_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ss_n |-> !spi_sclk);

    // R7: data out holds still through a high half-period
    a_r7_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R9: done marks the cycle in which select has just gone back high
    a_r9_done_at_ss_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_ss_n && !$past(spi_ss_n)));

    // R9: done lasts one cycle only
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: while a frame is active, select stays low until the frame ends
    a_r8_frame_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_ss_n && busy) |=> (!spi_ss_n || done));
endmodule

// File: tb/sim_spi_regacc.sv
module sim_spi_regacc;
    localparam int HD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       req_wr = 1'b0;
    logic [4:0] req_reg = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, spi_ss_n, spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;
    logic [7:0] rd_data, status;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    spi_regacc #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_reg(req_reg),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .status(status), .spi_ss_n(spi_ss_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- peripheral model ----------------
    logic [7:0]  mem [32];
    logic [7:0]  stat_byte = 8'h3C;
    logic [7:0]  mtx;
    logic [15:0] cap;
    logic [15:0] last_frame = '0;
    int          nbit = 0;
    int          rises = 0;
    int          last_rises = 0;
    int          frames = 0;

    always @(negedge spi_ss_n) begin
        mtx = stat_byte; spi_miso = mtx[7]; nbit = 0; rises = 0; cap = '0;
    end
    always @(posedge spi_sclk) begin
        cap = {cap[14:0], spi_mosi}; nbit++; rises++;
    end
    always @(negedge spi_sclk) begin
        if (!spi_ss_n) begin
            if (nbit == 8) mtx = mem[cap[7:3]];
            else           mtx = {mtx[6:0], 1'b0};
            spi_miso = mtx[7];
        end
    end
    always @(posedge spi_ss_n) begin
        if (rst_n) begin
            frames++; last_frame = cap; last_rises = rises;
            if (cap[9]) mem[cap[15:11]] = cap[7:0];
        end
    end

    // ---------------- pin monitors ----------------
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    int   mosi_bad = 0;
    int   hi_run = 0;
    int   min_gap = 1000;
    always @(negedge clk) begin
        if (rst_n && spi_sclk && prev_sclk && (spi_mosi != prev_mosi)) mosi_bad++;
        if (rst_n && spi_ss_n) hi_run++;
        else if (rst_n && !spi_ss_n && hi_run > 0) begin
            if (frames > 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
        prev_sclk = spi_sclk; prev_mosi = spi_mosi;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int ss_cyc, done_cnt, gap_cyc, done_bad;

    // Issue one request and follow the frame to idle.
    task automatic run_frame(input logic wr, input logic [4:0] r, input logic [7:0] d);
        int  guard;
        bit  seen;
        bit  prev_low;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_reg = r; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        ss_cyc = 0; done_cnt = 0; gap_cyc = 0; done_bad = 0; seen = 0; prev_low = 0;
        for (guard = 0; guard < 3000; guard++) begin
            if (!spi_ss_n) ss_cyc++;
            if (done) begin
                done_cnt++; seen = 1;
                if (!spi_ss_n || !prev_low) done_bad++;
            end
            if (seen && busy && spi_ss_n) gap_cyc++;
            if (seen && !busy) break;
            prev_low = !spi_ss_n;
            @(negedge clk);
        end
        if (guard >= 3000) chk("watchdog frame", 1, 0);
    endtask

    task automatic t_reset;
        chk("R1 ss_n", spi_ss_n, 1);
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 mosi", spi_mosi, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
    endtask

    task automatic t_read5;
        run_frame(1'b0, 5'd5, 8'hEE);
        chk("R2 read cmd byte", last_frame[15:8], 8'h28);
        chk("R3 read filler", last_frame[7:0], 8'h00);
        chk("R3 read data", rd_data, 8'hA5);
        chk("R5 status on read", status, 8'h3C);
        chk("R6 sclk rises", last_rises, 16);
        chk("R7 ss low cycles", ss_cyc, 32 * HD);
        chk("R9 done pulses", done_cnt, 1);
        chk("R9 done at ss rise", done_bad, 0);
        chk("R9 busy after done", gap_cyc, HD);
    endtask

    task automatic t_write31;
        stat_byte = 8'hC3;
        run_frame(1'b1, 5'd31, 8'h5A);
        chk("R2 write cmd byte", last_frame[15:8], 8'hFA);
        chk("R4 write data sent", last_frame[7:0], 8'h5A);
        chk("R4 rd_data kept", rd_data, 8'hA5);
        chk("R5 status on write", status, 8'hC3);
        chk("R4 peripheral got byte", mem[31], 8'h5A);
        run_frame(1'b0, 5'd31, 8'h00);
        chk("R3 read back 31", rd_data, 8'h5A);
    endtask

    task automatic t_reg0_ff;
        stat_byte = 8'h81;
        run_frame(1'b1, 5'd0, 8'hFF);
        chk("R2 cmd reg0 write", last_frame[15:8], 8'h02);
        chk("R4 data FF", last_frame[7:0], 8'hFF);
        run_frame(1'b0, 5'd0, 8'h77);
        chk("R2 cmd reg0 read", last_frame[15:8], 8'h00);
        chk("R3 read FF", rd_data, 8'hFF);
        chk("R5 status 81", status, 8'h81);
        run_frame(1'b1, 5'd0, 8'h00);
        run_frame(1'b0, 5'd0, 8'h00);
        chk("R3 read 00", rd_data, 8'h00);
    endtask

    task automatic t_busy_req;
        int f0;
        f0 = frames;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b0; req_reg = 5'd9; req_wdata = 8'h00;
        @(negedge clk);
        req = 1'b0;
        repeat (20) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_reg = 5'd17; req_wdata = 8'h99;
        @(negedge clk);
        req = 1'b0;
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R8 one frame only", frames - f0, 1);
        chk("R8 frame kept cmd", last_frame[15:8], 8'h48);
        chk("R8 reg17 untouched", mem[17], 8'd120);
        chk("R8 ss stays high", spi_ss_n, 1);
        chk("R3 read reg9", rd_data, 8'd64);
    endtask

    task automatic t_gap;
        run_frame(1'b0, 5'd2, 8'h00);
        run_frame(1'b0, 5'd3, 8'h00);
        chk("R9 min select gap", (min_gap >= HD), 1);
        chk("R7 mosi stable high", mosi_bad, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 8'(i * 7 + 1);
        mem[5] = 8'hA5;
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_read5;
        t_write31;
        t_reg0_ff;
        t_busy_req;
        t_gap;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #500000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule